// File: doc/BRIEF.md
# Branch Target Buffer Next-PC Predictor

This block picks the next fetch address while the current instruction is still being fetched, so before anything has been decoded. A direct-mapped table of 64 entries is indexed by word-address bits of the fetch PC. Each valid entry keeps the full PC of a control transfer, the target that was last seen and a 2-bit prediction state. When the fetch PC matches a stored PC and that entry's state leans taken, fetch is steered to the stored target. In every other case fetch moves on to PC+4. A non-branch instruction's PC can never match the table, so it never causes a false redirect.

The execute stage reports each resolved instruction through a resolution port. That report carries the actual outcome and target, and also the prediction that fetch made for the instruction. The block uses it to train existing entries and to allocate entries for taken control transfers. In the same cycle it raises a redirect together with the correct PC whenever the fetch-time guess was wrong. The pipeline kill that follows a redirect lives outside this block.

Top module: `btb_predictor`

## Requirements
- R1: After an active-low asynchronous reset every entry is invalid, so each fetch PC gives pred_hit_o = 0 and next_pc_o = fetch PC + 4.
- R2: The table is direct-mapped with 2^IDX_W entries (64 by default), indexed by PC bits [7:2]. Each entry is tagged with the full 32-bit PC. A PC that shares an index with a stored entry but differs in other bits misses. A taken control transfer at that PC replaces the stored entry.
- R3: On a lookup miss, next_pc_o = fetch PC + 4 and pred_taken_o = 0.
- R4: On a hit, pred_hit_o = 1. If the state leans taken (state bit 1 set), pred_taken_o = 1 and next_pc_o is the stored target. Otherwise next_pc_o = fetch PC + 4.
- R5: A resolution with res_is_ctrl_i = 0 never writes the table, whatever res_taken_i says, and it counts as actually not taken.
- R6: A resolved taken control transfer that misses the table allocates an entry holding its PC and target, in the weakly-taken state (2). A not-taken one that misses allocates nothing.
- R7: The prediction state is encoded as 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken. An outcome that agrees with the state's direction moves it to the strong state of that direction. A disagreeing outcome moves a strong state to the weak state of the same direction, and moves a weak state to the strong state of the opposite direction. The direction therefore flips only after two misses in a row from a strong state.
- R8: A resolved taken control transfer that hits rewrites the stored target with the resolved target and steps the state. A not-taken one that hits steps only the state.
- R9: In the cycle a resolution is valid, redirect_o = 1 when the actual direction differs from res_pred_taken_i, or when both are taken and res_target_i differs from res_pred_target_i. redirect_pc_o is the resolved target if the instruction was actually taken, and res_pc_i + 4 otherwise.
- R10: When a lookup and a write hit the same index in one cycle, the lookup returns the old contents. The written entry is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | 32 | PC being fetched |
| next_pc_o | output | 32 | Predicted next fetch PC |
| pred_hit_o | output | 1 | Fetch PC matched a valid entry |
| pred_taken_o | output | 1 | Lookup predicts a taken transfer |
| res_valid_i | input | 1 | Resolution report valid |
| res_is_ctrl_i | input | 1 | Resolved instruction is a branch or jump |
| res_taken_i | input | 1 | Resolved direction |
| res_pc_i | input | 32 | PC of resolved instruction |
| res_target_i | input | 32 | Resolved target |
| res_pred_taken_i | input | 1 | Direction fetch predicted for it |
| res_pred_target_i | input | 32 | Target fetch predicted for it |
| redirect_o | output | 1 | Fetch-time prediction was wrong |
| redirect_pc_o | output | 32 | Correct PC after a redirect |

## Verification
A vector table drives one entry through every state transition with alternating outcomes, and checks the fetch prediction after each resolution. This separates a hysteresis counter from a plain saturating one and from a 1-bit scheme. Aliasing PCs that share one index check that the tag covers the whole PC rather than only the index, and that a taken alias replaces the entry. Non-control reports claiming taken, and not-taken misses, check that allocation is restricted to taken transfers. Directed cases cover a lookup and a write in the same cycle, each redirect cause (wrong direction, wrong target, a phantom taken on a non-branch) and a reset after entries exist.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int unsigned PC_STEP = 4;
  localparam int unsigned IDX_LSB = 2;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  // agree -> strong same dir; disagree: strong -> weak same, weak -> strong opposite
  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    if (cur[1] == taken) begin
      nxt = taken ? CTR_ST : CTR_SNT;
    end else begin
      unique case (cur)
        CTR_ST:  nxt = CTR_WT;
        CTR_WT:  nxt = CTR_SNT;
        CTR_SNT: nxt = CTR_WNT;
        default: nxt = CTR_ST;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] fa_idx_i,
  output logic             fa_vld_o,
  output logic [PC_W-1:0]  fa_tag_o,
  output logic [PC_W-1:0]  fa_tgt_o,
  output ctr_e             fa_ctr_o,
  input  logic [IDX_W-1:0] ra_idx_i,
  output logic             ra_vld_o,
  output logic [PC_W-1:0]  ra_tag_o,
  output logic [PC_W-1:0]  ra_tgt_o,
  output ctr_e             ra_ctr_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic [PC_W-1:0]  w_tag_i,
  input  logic [PC_W-1:0]  w_tgt_i,
  input  ctr_e             w_ctr_i
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [PC_W-1:0]  tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [1:0]       ctr_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
      end else if (we_i && (w_idx_i == IDX_W'(e))) begin
        vld_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (we_i && (w_idx_i == IDX_W'(e))) begin
        tag_q[e] <= w_tag_i;
        tgt_q[e] <= w_tgt_i;
        ctr_q[e] <= w_ctr_i;
      end
    end
  end

  // reads see pre-write contents
  assign fa_vld_o = vld_q[fa_idx_i];
  assign fa_tag_o = tag_q[fa_idx_i];
  assign fa_tgt_o = tgt_q[fa_idx_i];
  assign fa_ctr_o = ctr_e'(ctr_q[fa_idx_i]);

  assign ra_vld_o = vld_q[ra_idx_i];
  assign ra_tag_o = tag_q[ra_idx_i];
  assign ra_tgt_o = tgt_q[ra_idx_i];
  assign ra_ctr_o = ctr_e'(ctr_q[ra_idx_i]);

  // R10 / R6: a write is visible on the next cycle
  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vld_q[$past(w_idx_i)] && tag_q[$past(w_idx_i)] == $past(w_tag_i)
              && tgt_q[$past(w_idx_i)] == $past(w_tgt_i)));

  // R2: with no write, an entry's contents hold
  p_idle_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(vld_q));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic             vld_i,
  input  logic [PC_W-1:0]  tag_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  ctr_e             ctr_i,
  output logic             hit_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  next_pc_o
);

  logic [PC_W-1:0] seq_pc;

  assign idx_o   = pc_i[IDX_LSB +: IDX_W];
  assign hit_o   = vld_i && (tag_i == pc_i);
  assign taken_o = hit_o && ctr_i[1];
  assign seq_pc  = pc_i + PC_W'(PC_STEP);

  always_comb begin
    next_pc_o = seq_pc;
    if (taken_o) next_pc_o = tgt_i;
  end

  // R4: taken prediction only from a hit
  p_taken_needs_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> hit_o);

  // R3: a miss never leaves the sequential path
  p_miss_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (next_pc_o == pc_i + PC_W'(PC_STEP)));

endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic             res_is_ctrl_i,
  input  logic             res_taken_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic [PC_W-1:0]  res_target_i,
  input  logic             res_pred_taken_i,
  input  logic [PC_W-1:0]  res_pred_target_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             rd_vld_i,
  input  logic [PC_W-1:0]  rd_tag_i,
  input  logic [PC_W-1:0]  rd_tgt_i,
  input  ctr_e             rd_ctr_i,
  output logic             we_o,
  output logic [IDX_W-1:0] w_idx_o,
  output logic [PC_W-1:0]  w_tag_o,
  output logic [PC_W-1:0]  w_tgt_o,
  output ctr_e             w_ctr_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o
);

  logic ctrl_ev, res_hit, act_taken, dir_wrong, tgt_wrong;

  assign rd_idx_o  = res_pc_i[IDX_LSB +: IDX_W];
  assign ctrl_ev   = res_valid_i && res_is_ctrl_i;
  assign res_hit   = rd_vld_i && (rd_tag_i == res_pc_i);
  assign act_taken = res_is_ctrl_i && res_taken_i;

  always_comb begin
    we_o    = 1'b0;
    w_idx_o = rd_idx_o;
    w_tag_o = res_pc_i;
    w_tgt_o = rd_tgt_i;
    w_ctr_o = rd_ctr_i;
    if (ctrl_ev && res_hit) begin
      we_o    = 1'b1;
      w_ctr_o = ctr_step(rd_ctr_i, res_taken_i);
      if (res_taken_i) w_tgt_o = res_target_i;
    end else if (ctrl_ev && res_taken_i) begin
      we_o    = 1'b1;
      w_tgt_o = res_target_i;
      w_ctr_o = CTR_WT;
    end
  end

  assign dir_wrong     = act_taken != res_pred_taken_i;
  assign tgt_wrong     = act_taken && res_pred_taken_i && (res_target_i != res_pred_target_i);
  assign redirect_o    = res_valid_i && (dir_wrong || tgt_wrong);
  assign redirect_pc_o = act_taken ? res_target_i : (res_pc_i + PC_W'(PC_STEP));

  // R5: non-control reports never write
  p_ctrl_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_is_ctrl_i) |-> !we_o);

  // R6: fresh allocation starts weakly taken
  p_alloc_weak_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !res_hit) |-> (w_ctr_o == CTR_WT && res_taken_i));

  // R7: one miss from strong taken keeps the taken direction
  p_hyst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && res_hit && rd_ctr_i == CTR_ST && !res_taken_i) |-> w_ctr_o[1]);

  // R9: no redirect without a report
  p_redirect_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> res_valid_i);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned PC_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  input  logic            res_valid_i,
  input  logic            res_is_ctrl_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic            res_pred_taken_i,
  input  logic [PC_W-1:0] res_pred_target_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);

  logic [IDX_W-1:0] fa_idx, ra_idx, w_idx;
  logic             fa_vld, ra_vld, we;
  logic [PC_W-1:0]  fa_tag, fa_tgt, ra_tag, ra_tgt, w_tag, w_tgt;
  ctr_e             fa_ctr, ra_ctr, w_ctr;

  btb_store #(.IDX_W(IDX_W), .PC_W(PC_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fa_idx_i (fa_idx),
    .fa_vld_o (fa_vld),
    .fa_tag_o (fa_tag),
    .fa_tgt_o (fa_tgt),
    .fa_ctr_o (fa_ctr),
    .ra_idx_i (ra_idx),
    .ra_vld_o (ra_vld),
    .ra_tag_o (ra_tag),
    .ra_tgt_o (ra_tgt),
    .ra_ctr_o (ra_ctr),
    .we_i     (we),
    .w_idx_i  (w_idx),
    .w_tag_i  (w_tag),
    .w_tgt_i  (w_tgt),
    .w_ctr_i  (w_ctr)
  );

  btb_lookup #(.IDX_W(IDX_W), .PC_W(PC_W)) u_lookup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pc_i      (fetch_pc_i),
    .idx_o     (fa_idx),
    .vld_i     (fa_vld),
    .tag_i     (fa_tag),
    .tgt_i     (fa_tgt),
    .ctr_i     (fa_ctr),
    .hit_o     (pred_hit_o),
    .taken_o   (pred_taken_o),
    .next_pc_o (next_pc_o)
  );

  btb_update #(.IDX_W(IDX_W), .PC_W(PC_W)) u_update (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .res_valid_i       (res_valid_i),
    .res_is_ctrl_i     (res_is_ctrl_i),
    .res_taken_i       (res_taken_i),
    .res_pc_i          (res_pc_i),
    .res_target_i      (res_target_i),
    .res_pred_taken_i  (res_pred_taken_i),
    .res_pred_target_i (res_pred_target_i),
    .rd_idx_o          (ra_idx),
    .rd_vld_i          (ra_vld),
    .rd_tag_i          (ra_tag),
    .rd_tgt_i          (ra_tgt),
    .rd_ctr_i          (ra_ctr),
    .we_o              (we),
    .w_idx_o           (w_idx),
    .w_tag_o           (w_tag),
    .w_tgt_o           (w_tgt),
    .w_ctr_o           (w_ctr),
    .redirect_o        (redirect_o),
    .redirect_pc_o     (redirect_pc_o)
  );

  // R1: nothing hits in the first cycle after reset
  p_reset_empty_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !pred_hit_o);

endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] next_pc;
  logic        hit, ptaken;
  logic        rv = 1'b0, rctrl = 1'b0, rtk = 1'b0, rptk = 1'b0;
  logic [31:0] rpc = '0, rtgt = '0, rptgt = '0;
  logic        redir;
  logic [31:0] redir_pc;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  btb_predictor uut (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .fetch_pc_i        (fetch_pc),
    .next_pc_o         (next_pc),
    .pred_hit_o        (hit),
    .pred_taken_o      (ptaken),
    .res_valid_i       (rv),
    .res_is_ctrl_i     (rctrl),
    .res_taken_i       (rtk),
    .res_pc_i          (rpc),
    .res_target_i      (rtgt),
    .res_pred_taken_i  (rptk),
    .res_pred_target_i (rptgt),
    .redirect_o        (redir),
    .redirect_pc_o     (redir_pc)
  );

  typedef struct packed {
    logic        rv;
    logic        ctrl;
    logic        tk;
    logic [31:0] rpc;
    logic [31:0] rtgt;
    logic [31:0] fpc;
    logic [31:0] exp_pc;
    logic        exp_hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  // A=0x1000 and B=0x2000 share index 0; C=0x1044 is index 17
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 32'h0,    32'h0,    32'h1000, 32'h1004, 1'b0, 4'd3}, // R3 empty miss
    '{1'b1, 1'b1, 1'b1, 32'h1000, 32'h3000, 32'h1000, 32'h3000, 1'b1, 4'd6}, // R6 alloc WT
    '{1'b0, 1'b0, 1'b0, 32'h0,    32'h0,    32'h2000, 32'h2004, 1'b0, 4'd2}, // R2 alias misses
    '{1'b1, 1'b0, 1'b1, 32'h1044, 32'h5000, 32'h1044, 32'h1048, 1'b0, 4'd5}, // R5 non-ctrl no write
    '{1'b1, 1'b1, 1'b0, 32'h1044, 32'h5000, 32'h1044, 32'h1048, 1'b0, 4'd6}, // R6 NT miss no alloc
    '{1'b1, 1'b1, 1'b0, 32'h1000, 32'h3000, 32'h1000, 32'h1004, 1'b1, 4'd7}, // R7 WT->SNT
    '{1'b1, 1'b1, 1'b1, 32'h1000, 32'h3000, 32'h1000, 32'h1004, 1'b1, 4'd7}, // R7 SNT->WNT
    '{1'b1, 1'b1, 1'b1, 32'h1000, 32'h3000, 32'h1000, 32'h3000, 1'b1, 4'd7}, // R7 WNT->ST
    '{1'b1, 1'b1, 1'b0, 32'h1000, 32'h3000, 32'h1000, 32'h3000, 1'b1, 4'd7}, // R7 ST->WT
    '{1'b1, 1'b1, 1'b1, 32'h1000, 32'h3400, 32'h1000, 32'h3400, 1'b1, 4'd8}, // R8 new target
    '{1'b1, 1'b1, 1'b0, 32'h1000, 32'h3000, 32'h1000, 32'h3400, 1'b1, 4'd8}, // R8 NT keeps target
    '{1'b1, 1'b1, 1'b0, 32'h1000, 32'h3000, 32'h1000, 32'h1004, 1'b1, 4'd4}, // R4 hit, not taken
    '{1'b1, 1'b1, 1'b1, 32'h2000, 32'h6000, 32'h2000, 32'h6000, 1'b1, 4'd2}, // R2 alias replaces
    '{1'b0, 1'b0, 1'b0, 32'h0,    32'h0,    32'h1000, 32'h1004, 1'b0, 4'd2}  // R2 evicted
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic drive_res(logic v, logic c, logic t, logic [31:0] pc, logic [31:0] tg,
                           logic pt, logic [31:0] ptg);
    rv = v; rctrl = c; rtk = t; rpc = pc; rtgt = tg; rptk = pt; rptgt = ptg;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    fetch_pc = 32'h1000;
    #1;
    check("R1", {31'b0, hit}, 32'd0);
    check("R1", next_pc, 32'h1004);
    check("R1", {31'b0, redir}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive_res(VECS[i].rv, VECS[i].ctrl, VECS[i].tk, VECS[i].rpc, VECS[i].rtgt, 1'b0, 32'h0);
      fetch_pc = 32'h0;
      @(negedge clk);
      rv = 1'b0;
      fetch_pc = VECS[i].fpc;
      #1;
      check($sformatf("R%0d", VECS[i].req), next_pc, VECS[i].exp_pc);
      check($sformatf("R%0d", VECS[i].req), {31'b0, hit}, {31'b0, VECS[i].exp_hit});
    end

    // R10 same-cycle lookup and allocate at C
    @(negedge clk);
    drive_res(1'b1, 1'b1, 1'b1, 32'h1044, 32'h7000, 1'b0, 32'h0);
    fetch_pc = 32'h1044;
    #1;
    check("R10", next_pc, 32'h1048);
    check("R10", {31'b0, hit}, 32'd0);
    @(negedge clk);
    rv = 1'b0;
    #1;
    check("R10", next_pc, 32'h7000);
    check("R4", {31'b0, ptaken}, 32'd1);

    // R9 redirect causes
    @(negedge clk);
    drive_res(1'b1, 1'b1, 1'b1, 32'h1044, 32'h7100, 1'b0, 32'h0);
    #1;
    check("R9", {31'b0, redir}, 32'd1);
    check("R9", redir_pc, 32'h7100);
    @(negedge clk);
    drive_res(1'b1, 1'b1, 1'b1, 32'h1044, 32'h7100, 1'b1, 32'h7100);
    #1;
    check("R9", {31'b0, redir}, 32'd0);
    @(negedge clk);
    drive_res(1'b1, 1'b1, 1'b0, 32'h1044, 32'h7100, 1'b1, 32'h7100);
    #1;
    check("R9", {31'b0, redir}, 32'd1);
    check("R9", redir_pc, 32'h1048);
    @(negedge clk);
    drive_res(1'b1, 1'b1, 1'b1, 32'h1044, 32'h7200, 1'b1, 32'h7100);
    #1;
    check("R9", {31'b0, redir}, 32'd1);
    check("R9", redir_pc, 32'h7200);
    @(negedge clk);
    drive_res(1'b1, 1'b0, 1'b1, 32'h1044, 32'h9000, 1'b1, 32'h9000);
    #1;
    check("R5", {31'b0, redir}, 32'd1);
    check("R5", redir_pc, 32'h1048);
    @(negedge clk);
    rv = 1'b0;
    #1;
    check("R9", {31'b0, redir}, 32'd0);
    // C last trained taken to 0x7200 (non-ctrl report ignored)
    check("R5", next_pc, 32'h7200);

    // R1 reset clears populated table
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", {31'b0, hit}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", next_pc, 32'h1048);
    fetch_pc = 32'h2000;
    #1;
    check("R1", next_pc, 32'h2004);

    finish_run();
  end

endmodule